// File: doc/BRIEF.md
# Parity-Protected Clear-On-Read Status Bank

This block holds four 8-bit status words for the serial register interface of a motor driver. Three of them are sticky flag words: event pulses from fault detectors (overcurrent, thermal, open coil and the like) set bits that stay set until software reads the word. The fourth word carries a live 7-bit position value. The top bit of every word is an even-parity bit over the seven data bits below it. The bit is computed from the stored data whenever the word is presented. A registered-only error output goes high while any flag word holds a set bit.

The serial engine owns the chip-select level. The bank refreshes its contents only on clock edges where chip select is high, which means the bus is idle. Events that arrive during a transfer collect in a pending store and are merged at the first idle edge, so none are lost. A read strobe with an address arms a clear of that flag word. The clear is carried out at the first idle edge after the read. An event arriving on that same edge survives the clear.

Top module: `stat_bank`

## Requirements
- R1: After a synchronous reset, all four words read 0x00 on `stat_o` and `rd_data`, and `err_o` is low.
- R2: Bit 7 of every presented word is 1 exactly when bits 6:0 hold an odd number of ones.
- R3: With `spi_sel_n` high, a pulse on `evt_i[7*w+b]` sets bit b of flag word w (w = 0..2) one clock edge later, and the bit stays set after the pulse ends.
- R4: Events seen while `spi_sel_n` is low change no word. They appear in their word at the first clock edge that samples `spi_sel_n` high.
- R5: `err_o` is high exactly when a flag word 0..2 has a nonzero data field. Word 3 never affects it, and it rises only on edges that sample `spi_sel_n` high.
- R6: A `rd_stb` naming flag word w leaves that word unchanged while `spi_sel_n` stays low. It clears only word w at the first edge that samples `spi_sel_n` high.
- R7: An event that reaches a word on the same edge as that word's pending clear is kept.
- R8: Word 3 (`stat_o[31:24]`) loads `pos_i` on every edge that samples `spi_sel_n` high, holds while it is low, and is never cleared by a read.
- R9: `rd_data` shows the word selected by `rd_addr` (0, 1, 2 = flag words, 3 = position) combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel_n | input | 1 | Chip-select level, low while a transfer is in progress |
| evt_i | input | 21 | Event pulses, 7 per flag word, word w at bits 7w+6:7w |
| pos_i | input | 7 | Live position value for word 3 |
| rd_stb | input | 1 | One-cycle read strobe from the serial engine |
| rd_addr | input | 2 | Word selected for read |
| rd_data | output | 8 | Parity-encoded word at `rd_addr` |
| stat_o | output | 32 | All four parity-encoded words, word w at bits 8w+7:8w |
| err_o | output | 1 | High while any flag word holds a set bit |

## Verification
Words and `err_o` change at the first rising edge that samples `spi_sel_n` high after the stimulus. That is one edge after an event pulse or chip-select rise driven on the falling edge. `rd_data` is combinational and is due in the same cycle as `rd_addr`. The bench drives all inputs on falling edges and samples one full edge later, or, for `rd_data`, a nanosecond after the address changes. While chip select is low it samples again after several edges, to show that nothing moved.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int STAT_DW    = 7;
    localparam int STAT_NFLAG = 3;
    localparam int STAT_NREG  = STAT_NFLAG + 1;
    localparam int STAT_AW    = $clog2(STAT_NREG);

    typedef enum logic [STAT_AW-1:0] {
        ADDR_FLAG0 = 2'd0,
        ADDR_FLAG1 = 2'd1,
        ADDR_FLAG2 = 2'd2,
        ADDR_POS   = 2'd3
    } stat_addr_e;

    typedef struct packed {
        logic               par;
        logic [STAT_DW-1:0] data;
    } stat_word_t;

    function automatic stat_word_t stat_encode(input logic [STAT_DW-1:0] d);
        stat_word_t w;
        w.data = d;
        w.par  = ^d;
        return w;
    endfunction
endpackage

// File: rtl/stat_flag_reg.sv
module stat_flag_reg #(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_en,
    input  logic [DW-1:0] evt,
    input  logic          clr_req,
    output logic [DW-1:0] q
);
    logic [DW-1:0] pend_q;
    logic          clr_pend_q;
    logic [DW-1:0] base;

    // an armed clear drops old contents; new and pending events still land
    assign base = clr_pend_q ? '0 : q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q          <= '0;
            pend_q     <= '0;
            clr_pend_q <= 1'b0;
        end else if (upd_en) begin
            q          <= base | pend_q | evt;
            pend_q     <= '0;
            clr_pend_q <= clr_req;
        end else begin
            pend_q     <= pend_q | evt;
            clr_pend_q <= clr_pend_q | clr_req;
        end
    end
endmodule

// File: rtl/stat_pos_reg.sv
module stat_pos_reg #(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_en,
    input  logic [DW-1:0] pos,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (upd_en) q <= pos;
    end
endmodule

// File: rtl/stat_rd_mux.sv
module stat_rd_mux #(
    parameter int NREG = 4,
    parameter int WW   = 8,
    parameter int AW   = 2
) (
    input  logic [NREG*WW-1:0] words,
    input  logic [AW-1:0]      sel,
    output logic [WW-1:0]      dout
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel == AW'(i)) dout = words[i*WW +: WW];
        end
    end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         spi_sel_n,
    input  logic [STAT_NFLAG*STAT_DW-1:0] evt_i,
    input  logic [STAT_DW-1:0]           pos_i,
    input  logic                         rd_stb,
    input  logic [STAT_AW-1:0]           rd_addr,
    output logic [STAT_DW:0]             rd_data,
    output logic [STAT_NREG*(STAT_DW+1)-1:0] stat_o,
    output logic                         err_o
);
    localparam int WW = STAT_DW + 1;

    logic                   upd_en;
    logic [STAT_DW-1:0]     flag_q [STAT_NFLAG];
    logic [STAT_DW-1:0]     pos_q;
    logic [STAT_NFLAG-1:0]  flag_any;
    stat_word_t             enc [STAT_NREG];

    assign upd_en = spi_sel_n;

    for (genvar w = 0; w < STAT_NFLAG; w++) begin : g_flag
        logic clr_req;
        assign clr_req = rd_stb && (rd_addr == STAT_AW'(w));
        stat_flag_reg #(.DW(STAT_DW)) u_flag (
            .clk     (clk),
            .rst     (rst),
            .upd_en  (upd_en),
            .evt     (evt_i[w*STAT_DW +: STAT_DW]),
            .clr_req (clr_req),
            .q       (flag_q[w])
        );
        assign flag_any[w] = |flag_q[w];
        assign enc[w]      = stat_encode(flag_q[w]);
    end

    stat_pos_reg #(.DW(STAT_DW)) u_pos (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .pos    (pos_i),
        .q      (pos_q)
    );
    assign enc[ADDR_POS] = stat_encode(pos_q);

    for (genvar r = 0; r < STAT_NREG; r++) begin : g_out
        assign stat_o[r*WW +: WW] = enc[r];
    end

    stat_rd_mux #(.NREG(STAT_NREG), .WW(WW), .AW(STAT_AW)) u_mux (
        .words (stat_o),
        .sel   (rd_addr),
        .dout  (rd_data)
    );

    assign err_o = |flag_any;
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic        spi_sel_n,
    input logic [20:0] evt_i,
    input logic [6:0]  pos_i,
    input logic [7:0]  rd_data,
    input logic [31:0] stat_o,
    input logic        err_o
);
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (stat_o == 32'd0 && !err_o));

    p_parity_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[7] == ^rd_data[6:0]);

    p_latch_r3: assert property (@(posedge clk) disable iff (rst)
        spi_sel_n |=> ((stat_o[6:0] & $past(evt_i[6:0])) == $past(evt_i[6:0])));

    p_hold_low_r4: assert property (@(posedge clk) disable iff (rst)
        !spi_sel_n |=> $stable(stat_o));

    p_err_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(spi_sel_n));

    p_pos_load_r8: assert property (@(posedge clk) disable iff (rst)
        spi_sel_n |=> (stat_o[30:24] == $past(pos_i)));
endmodule

bind stat_bank stat_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .spi_sel_n (spi_sel_n),
    .evt_i     (evt_i),
    .pos_i     (pos_i),
    .rd_data   (rd_data),
    .stat_o    (stat_o),
    .err_o     (err_o)
);

// File: tb/stat_bank_bench.sv
module stat_bank_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        spi_sel_n;
    logic [20:0] evt_i;
    logic [6:0]  pos_i;
    logic        rd_stb;
    logic [1:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [31:0] stat_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    stat_bank u_stat_bank (
        .clk(clk), .rst(rst), .spi_sel_n(spi_sel_n), .evt_i(evt_i),
        .pos_i(pos_i), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .stat_o(stat_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] word(input int w);
        return stat_o[w*8 +: 8];
    endfunction

    task automatic pulse_evt(input int w, input logic [6:0] bits);
        evt_i[w*7 +: 7] = bits;
        step();
        evt_i = '0;
    endtask

    task automatic do_read(input logic [1:0] a);
        rd_addr = a;
        rd_stb  = 1'b1;
        step();
        rd_stb  = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 words", stat_o, 32'h0);
        chk("R1 err", {31'd0, err_o}, 32'd0);
        rd_addr = 2'd0; #1;
        chk("R1 rd_data", {24'd0, rd_data}, 32'h0);
    endtask

    task automatic t_event_high;
        pulse_evt(0, 7'b0000101);
        chk("R3 latch even", {24'd0, word(0)}, 32'h05);
        chk("R5 err set", {31'd0, err_o}, 32'd1);
        step(3);
        chk("R3 sticky", {24'd0, word(0)}, 32'h05);
        pulse_evt(0, 7'b0000010);
        chk("R2 odd parity", {24'd0, word(0)}, 32'h87);
    endtask

    task automatic t_read_clear;
        pulse_evt(2, 7'h7F);
        chk("R2 all ones", {24'd0, word(2)}, 32'hFF);
        spi_sel_n = 1'b0;
        rd_addr = 2'd0; #1;
        chk("R9 rd addr0", {24'd0, rd_data}, 32'h87);
        do_read(2'd0);
        step(3);
        chk("R6 held low", {24'd0, word(0)}, 32'h87);
        spi_sel_n = 1'b1;
        step();
        chk("R6 cleared", {24'd0, word(0)}, 32'h00);
        chk("R6 other kept", {24'd0, word(2)}, 32'hFF);
        spi_sel_n = 1'b0;
        do_read(2'd2);
        spi_sel_n = 1'b1;
        step();
        chk("R6 clear w2", {24'd0, word(2)}, 32'h00);
        chk("R5 err clear", {31'd0, err_o}, 32'd0);
    endtask

    task automatic t_event_low;
        spi_sel_n = 1'b0;
        pulse_evt(1, 7'b1000000);
        step(4);
        chk("R4 hidden", {24'd0, word(1)}, 32'h00);
        chk("R4 err low", {31'd0, err_o}, 32'd0);
        spi_sel_n = 1'b1;
        step();
        chk("R4 merged", {24'd0, word(1)}, 32'hC0);
        chk("R5 err after merge", {31'd0, err_o}, 32'd1);
    endtask

    task automatic t_race;
        spi_sel_n = 1'b0;
        do_read(2'd1);
        spi_sel_n = 1'b1;
        evt_i[7 +: 7] = 7'b0000001;
        step();
        evt_i = '0;
        chk("R7 event wins", {24'd0, word(1)}, 32'h81);
        spi_sel_n = 1'b0;
        do_read(2'd1);
        spi_sel_n = 1'b1;
        step();
        chk("R6 clear w1", {24'd0, word(1)}, 32'h00);
    endtask

    task automatic t_pos;
        pos_i = 7'h55;
        step();
        chk("R8 load even", {24'd0, word(3)}, 32'h55);
        pos_i = 7'h07;
        step();
        chk("R8 load odd", {24'd0, word(3)}, 32'h87);
        chk("R5 pos excluded", {31'd0, err_o}, 32'd0);
        spi_sel_n = 1'b0;
        pos_i = 7'h01;
        step(3);
        chk("R8 hold low", {24'd0, word(3)}, 32'h87);
        do_read(2'd3);
        pos_i = 7'h07;
        spi_sel_n = 1'b1;
        step();
        chk("R8 not cleared", {24'd0, word(3)}, 32'h87);
        rd_addr = 2'd3; #1;
        chk("R9 rd addr3", {24'd0, rd_data}, 32'h87);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; spi_sel_n = 1'b1; evt_i = '0; pos_i = '0;
        rd_stb = 1'b0; rd_addr = '0;
        step(3);
        rst = 1'b0;
        step();
        t_reset();
        t_event_high();
        t_read_clear();
        t_event_low();
        t_race();
        t_pos();
        finish_run();
    end
endmodule